// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block takes eight level-sensitive PCI interrupt request lines and one system control interrupt (SCI) level, and steers them onto two sets of outputs: sixteen legacy interrupt-controller input lines and twenty-four APIC global system interrupt (GSI) lines. Each request line has its own routing byte. That byte either names the legacy line the request is merged onto or cuts the request off from the legacy side. Every request line also drives one fixed GSI, whatever its routing byte holds.

Software programs the routing bytes and a small SCI target field through a byte-wide write/read port. Several sources may land on the same legacy line; they are ORed together. The SCI is merged into the GSI that its target field selects. It also reaches the legacy line of the same number when that number is below sixteen. The SCI level passes through a stored-level stage that changes only when the input differs from the held value. All outputs come from flops.

Top module: `irq_router`

## Requirements
- R1: After reset, every routing byte reads 0x80, the SCI target field reads 0x00, and `pic_irq_o` and `gsi_o` are all zero.
- R2: Register map on `cfg_addr`: 0x0–0x3 hold the routing bytes of request lines 0–3, 0x8–0xB those of lines 4–7, and 0x4 the SCI target field. A routing byte keeps bits 7 and 3:0 and reads other bits as 0. The SCI target keeps bits 2:0 only. Any other address reads 0x00 and ignores writes. `cfg_rdata` follows `cfg_addr` without a clock.
- R3: A legacy line is high when at least one request line is high whose routing byte has bit 7 clear and bits 3:0 equal to that line number. A routing byte with bit 7 set keeps its request off every legacy line.
- R4: Request line n always drives GSI 16+n, whatever its routing byte holds.
- R5: SCI target decode on bits 2:0: 0 selects line 9, 1 selects 10, 2 selects 11, 4 selects 20, 5 selects 21. Codes 3, 6 and 7 route the SCI nowhere.
- R6: A high SCI level sets the GSI of the selected line. It sets the legacy line of the same number only when that number is below 16, so lines 20 and 21 reach the GSI outputs alone.
- R7: Outputs are registered. A request level sampled at a clock edge shows at the outputs after that edge. A register write shows one edge after the write edge. The SCI input shows one edge after it is captured into the stored level, and that stored level changes only when the input differs from it.
- R8: With no request high and the SCI low, all outputs are zero. GSI lines 0–15 are never driven except by the SCI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Byte write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` |
| pirq_in | input | 8 | Request levels, bit n is line n |
| sci_in | input | 1 | System control interrupt level |
| pic_irq_o | output | 16 | Legacy controller line levels |
| gsi_o | output | 24 | APIC GSI levels |

## Verification
The assertions assume that the request and SCI levels are ordinary synchronous inputs that settle before each clock edge. They also assume that the SCI target field is the only thing that decides where the SCI lands. The output checks compare against levels taken one cycle earlier, so they count on register writes and input changes being seen one edge at a time. The stimulus drives every input on the falling edge. It holds the inputs for three cycles before it compares, so each random draw of routing bytes, target code and levels has settled through both register stages.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int LINE_W = 4;

  typedef struct packed {
    logic              cut;
    logic [LINE_W-1:0] line;
  } route_t;

  typedef struct packed {
    logic       hit;
    logic [4:0] line;
  } sci_tgt_t;

  function automatic route_t route_from_byte(input logic [7:0] b);
    route_t r;
    r.cut  = b[7];
    r.line = b[LINE_W-1:0];
    return r;
  endfunction

  function automatic logic [7:0] route_to_byte(input route_t r);
    return {r.cut, 3'b000, r.line};
  endfunction

  function automatic sci_tgt_t sci_decode(input logic [2:0] code);
    sci_tgt_t t;
    t.hit = 1'b1;
    case (code)
      3'd0:    t.line = 5'd9;
      3'd1:    t.line = 5'd10;
      3'd2:    t.line = 5'd11;
      3'd4:    t.line = 5'd20;
      3'd5:    t.line = 5'd21;
      default: begin t.hit = 1'b0; t.line = 5'd0; end
    endcase
    return t;
  endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_PIRQ  = 8,
  parameter int AW        = 4,
  parameter int LO_BASE   = 0,
  parameter int HI_BASE   = 8,
  parameter int SCI_ADDR  = 4,
  parameter logic [7:0] ROUTE_RST = 8'h80,
  parameter logic [2:0] SCI_RST   = 3'd0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [AW-1:0]              addr,
  input  logic [7:0]                 wdata,
  output logic [7:0]                 rdata,
  output route_t [NUM_PIRQ-1:0]      route_o,
  output logic [2:0]                 sci_sel_o
);
  localparam int HALF = NUM_PIRQ / 2;

  function automatic logic [AW-1:0] slot_addr(input int idx);
    return (idx < HALF) ? AW'(LO_BASE + idx) : AW'(HI_BASE + idx - HALF);
  endfunction

  route_t [NUM_PIRQ-1:0] route_q;
  logic   [2:0]          sci_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PIRQ; i++) route_q[i] <= route_from_byte(ROUTE_RST);
      sci_q <= SCI_RST;
    end else if (we) begin
      for (int i = 0; i < NUM_PIRQ; i++)
        if (addr == slot_addr(i)) route_q[i] <= route_from_byte(wdata);
      if (addr == AW'(SCI_ADDR)) sci_q <= wdata[2:0];
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NUM_PIRQ; i++)
      if (addr == slot_addr(i)) rdata = route_to_byte(route_q[i]);
    if (addr == AW'(SCI_ADDR)) rdata = {5'b00000, sci_q};
  end

  assign route_o   = route_q;
  assign sci_sel_o = sci_q;
endmodule

// File: rtl/irq_sci_tracker.sv
module irq_sci_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic sci_in,
  output logic sci_lvl_o,
  output logic sci_change_o
);
  logic lvl_q;

  assign sci_change_o = (sci_in != lvl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            lvl_q <= 1'b0;
    else if (sci_change_o) lvl_q <= sci_in;
  end

  assign sci_lvl_o = lvl_q;
endmodule

// File: rtl/irq_merge.sv
module irq_merge
  import irq_router_pkg::*;
#(
  parameter int NUM_PIRQ  = 8,
  parameter int PIC_LINES = 16,
  parameter int GSI_LINES = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PIRQ-1:0]   pirq,
  input  route_t [NUM_PIRQ-1:0] route,
  input  logic [2:0]            sci_sel,
  input  logic                  sci_lvl,
  output logic [PIC_LINES-1:0]  pic_o,
  output logic [GSI_LINES-1:0]  gsi_o
);
  logic [PIC_LINES-1:0] pic_next;
  logic [GSI_LINES-1:0] gsi_next;
  sci_tgt_t             tgt;

  assign tgt = sci_decode(sci_sel);

  always_comb begin
    pic_next = '0;
    gsi_next = '0;
    for (int i = 0; i < NUM_PIRQ; i++) begin
      gsi_next[PIC_LINES + i] = pirq[i];
      if (!route[i].cut && int'(route[i].line) < PIC_LINES && pirq[i])
        pic_next[route[i].line] = 1'b1;
    end
    if (tgt.hit && sci_lvl) begin
      if (int'(tgt.line) < GSI_LINES) gsi_next[tgt.line] = 1'b1;
      if (int'(tgt.line) < PIC_LINES) pic_next[tgt.line[LINE_W-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pic_o <= '0;
      gsi_o <= '0;
    end else begin
      pic_o <= pic_next;
      gsi_o <= gsi_next;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_PIRQ  = 8,
  parameter int PIC_LINES = 16,
  parameter int GSI_LINES = 24,
  parameter int AW        = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  input  logic [NUM_PIRQ-1:0]  pirq_in,
  input  logic                 sci_in,
  output logic [PIC_LINES-1:0] pic_irq_o,
  output logic [GSI_LINES-1:0] gsi_o
);
  route_t [NUM_PIRQ-1:0] route;
  logic   [2:0]          sci_sel;
  logic                  sci_lvl;
  logic                  sci_change;

  irq_route_regs #(.NUM_PIRQ(NUM_PIRQ), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .route_o(route), .sci_sel_o(sci_sel)
  );

  irq_sci_tracker u_sci (
    .clk(clk), .rst_n(rst_n), .sci_in(sci_in),
    .sci_lvl_o(sci_lvl), .sci_change_o(sci_change)
  );

  irq_merge #(.NUM_PIRQ(NUM_PIRQ), .PIC_LINES(PIC_LINES), .GSI_LINES(GSI_LINES)) u_merge (
    .clk(clk), .rst_n(rst_n), .pirq(pirq_in), .route(route), .sci_sel(sci_sel),
    .sci_lvl(sci_lvl), .pic_o(pic_irq_o), .gsi_o(gsi_o)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_PIRQ  = 8,
  parameter int PIC_LINES = 16,
  parameter int GSI_LINES = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PIRQ-1:0]  pirq_in,
  input logic                 sci_in,
  input logic                 sci_lvl,
  input logic                 sci_change,
  input logic [2:0]           sci_sel,
  input logic [PIC_LINES-1:0] pic_irq_o,
  input logic [GSI_LINES-1:0] gsi_o
);
  // R4
  pirq_gsi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gsi_o[PIC_LINES +: NUM_PIRQ] & $past(pirq_in)) == $past(pirq_in)));

  // R8
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!($past(pirq_in) == '0 && !$past(sci_lvl)) || (pic_irq_o == '0 && gsi_o == '0)));

  // R6
  sci_apic_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!($past(pirq_in) == '0 && $past(sci_lvl) && $past(sci_sel) == 3'd4)
              || (pic_irq_o == '0 && gsi_o[20])));

  // R5
  sci_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!($past(pirq_in) == '0 && ($past(sci_sel) == 3'd3 || $past(sci_sel) >= 3'd6))
              || (pic_irq_o == '0 && gsi_o == '0)));

  // R7
  sci_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sci_in == sci_lvl) |=> $stable(sci_lvl));

  // R7
  sci_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sci_change |=> (sci_lvl == $past(sci_in)));
endmodule

bind irq_router irq_router_chk #(
  .NUM_PIRQ(NUM_PIRQ), .PIC_LINES(PIC_LINES), .GSI_LINES(GSI_LINES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .sci_in(sci_in), .sci_lvl(sci_lvl),
  .sci_change(sci_change), .sci_sel(sci_sel), .pic_irq_o(pic_irq_o), .gsi_o(gsi_o)
);

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = 4'h0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [7:0]  pirq_in = 8'h00;
  logic        sci_in = 1'b0;
  logic [15:0] pic_irq_o;
  logic [23:0] gsi_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] rtab [8];
  logic [2:0] ssel;

  always #2 clk = ~clk;

  irq_router i_irq_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pirq_in(pirq_in), .sci_in(sci_in),
    .pic_irq_o(pic_irq_o), .gsi_o(gsi_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] rslot(input int n);
    return (n < 4) ? 4'(n) : 4'(n + 4);
  endfunction

  function automatic int sci_target(input logic [2:0] c);
    if (c <= 3'd2) return 9 + int'(c);
    if (c == 3'd4 || c == 3'd5) return 16 + int'(c);
    return -1;
  endfunction

  function automatic logic [15:0] exp_pic(input logic [7:0] p, input logic s);
    logic [15:0] v = '0;
    int t = sci_target(ssel);
    for (int n = 0; n < 8; n++)
      if (p[n] && !rtab[n][7]) v = v | (16'h1 << rtab[n][3:0]);
    if (s && t >= 0 && t < 16) v = v | (16'h1 << t);
    return v;
  endfunction

  function automatic logic [23:0] exp_gsi(input logic [7:0] p, input logic s);
    logic [23:0] v = {p, 16'h0000};
    int t = sci_target(ssel);
    if (s && t >= 0) v = v | (24'h1 << t);
    return v;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
    cfg_addr = a;
    #0.5;
    check(req, {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  task automatic set_route(input int n, input logic [7:0] b);
    wr(rslot(n), b);
    rtab[n] = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int n = 0; n < 8; n++) rtab[n] = 8'h80;
    ssel = 3'd0;
    repeat (3) @(negedge clk);
    // R1: reset values while reset held and just after release
    check("R1 pic", 32'(pic_irq_o), 32'h0);
    check("R1 gsi", 32'(gsi_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 8; n++) rd_check("R1 route", rslot(n), 8'h80);
    rd_check("R1 sci", 4'h4, 8'h00);

    // R2: masking and unmapped addresses
    set_route(0, 8'hF5); rtab[0] = 8'h85;
    rd_check("R2 route mask", 4'h0, 8'h85);
    wr(4'h4, 8'hFA);
    rd_check("R2 sci mask", 4'h4, 8'h02);
    wr(4'h4, 8'h00);
    wr(4'h6, 8'h3C);
    rd_check("R2 unmapped", 4'h6, 8'h00);
    wr(4'hF, 8'h11);
    rd_check("R2 unmapped F", 4'hF, 8'h00);
    for (int n = 1; n < 8; n++) rd_check("R2 untouched", rslot(n), 8'h80);
    set_route(7, 8'h0C);
    rd_check("R2 high bank", 4'hB, 8'h0C);

    // R7 / R3 / R4: timing of request path
    set_route(0, 8'h05);
    @(negedge clk);
    pirq_in = 8'h01;
    @(negedge clk);
    check("R7 R3 pic after one edge", 32'(pic_irq_o), 32'h0020);
    check("R7 R4 gsi after one edge", 32'(gsi_o), 32'h010000);
    wr(4'h0, 8'h85); rtab[0] = 8'h85;
    check("R7 write not yet visible", 32'(pic_irq_o), 32'h0020);
    @(negedge clk);
    check("R3 cut bit", 32'(pic_irq_o), 32'h0);
    check("R4 gsi ignores cut", 32'(gsi_o), 32'h010000);
    pirq_in = 8'h00;

    // R7 / R6: SCI path has the stored-level stage
    @(negedge clk);
    sci_in = 1'b1;
    @(negedge clk);
    check("R7 sci not yet", 32'(gsi_o), 32'h0);
    @(negedge clk);
    check("R6 sci gsi9", 32'(gsi_o), 32'h000200);
    check("R6 sci pic9", 32'(pic_irq_o), 32'h0200);
    wr(4'h4, 8'h05); ssel = 3'd5;
    @(negedge clk);
    check("R6 sci line21 gsi", 32'(gsi_o), 32'h200000);
    check("R6 sci line21 no pic", 32'(pic_irq_o), 32'h0);
    wr(4'h4, 8'h06); ssel = 3'd6;
    @(negedge clk);
    check("R5 sci nowhere", 32'(gsi_o), 32'h0);
    sci_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 quiet", 32'(gsi_o), 32'h0);

    // R3: several requests merged on one line
    set_route(2, 8'h03); set_route(6, 8'h03);
    pirq_in = 8'h44;
    repeat (2) @(negedge clk);
    check("R3 shared line", 32'(pic_irq_o), 32'h0008);
    pirq_in = 8'h40;
    @(negedge clk);
    check("R3 shared one source", 32'(pic_irq_o), 32'h0008);

    // random sweep: R3 R4 R5 R6 R8
    for (int it = 0; it < 300; it++) begin
      for (int n = 0; n < 8; n++) set_route(n, 8'($urandom));
      ssel = 3'($urandom);
      wr(4'h4, {5'b0, ssel});
      @(negedge clk);
      pirq_in = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      sci_in  = 1'($urandom);
      repeat (3) @(negedge clk);
      check("R3 R6 random pic", 32'(pic_irq_o), 32'(exp_pic(pirq_in, sci_in)));
      check("R4 R5 R8 random gsi", 32'(gsi_o), 32'(exp_gsi(pirq_in, sci_in)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule